// File: doc/BRIEF.md
# Paged Memory Address Translator

This block turns a 16-bit logical address from the processor into an 18-bit global address. A fixed 16 KB window of the logical map, at 0x8000 to 0xBFFF, is remapped through a 4-bit program page index. Any one of sixteen 16 KB flash blocks can therefore appear in the window, which reaches 256 KB of global space. Logical addresses outside the window pass through unchanged under a constant upper prefix.

The block also holds a direct-page byte for short-form data accesses. On such an access, that byte becomes the upper half of the logical address and the 8-bit short operand becomes the lower half. The result is then translated the same way as any other logical address.

Both registers sit on a small register bus with a combinational read path. The page index can be rewritten at any time. The direct-page byte accepts only the first write after reset. Address translation is purely combinational.

Top module: `paged_xlat`

## Requirements
- R1: After reset, the page index register (register address 0x15) reads 0x0E and the direct-page register (register address 0x11) reads 0x00.
- R2: A write to register address 0x15 stores write-data bits 3:0 as the page index. Bits 7:4 of that register always read as zero. Writes are accepted any number of times.
- R3: `win_hit` is 1 exactly when the logical address lies in 0x8000..0xBFFF, that is, when logical bits 15:14 equal binary 10.
- R4: When `win_hit` is 1, `glob_addr` is the page index in bits 17:14, with logical address bits 13:0 in bits 13:0.
- R5: When `win_hit` is 0, `glob_addr` is binary 11 in bits 17:16, with the 16-bit logical address in bits 15:0.
- R6: When `direct_acc` is 1, the logical address is the direct-page byte in bits 15:8 and `short_op` in bits 7:0. When it is 0, the logical address is `cpu_addr`.
- R7: The first write to register address 0x11 after reset loads the direct-page byte. Every later write leaves it unchanged until the next reset.
- R8: Reads at any register address other than 0x11 and 0x15 return 0x00.
- R9: `glob_addr` and `win_hit` follow the inputs within the same cycle. A register write becomes visible on the clock edge at which `reg_wr` is sampled high, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | Logical address for normal accesses |
| short_op | input | 8 | Short operand for direct-form accesses |
| direct_acc | input | 1 | 1 selects a direct-form access |
| reg_addr | input | 8 | Register bus address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| glob_addr | output | 18 | Translated global address |
| win_hit | output | 1 | Logical address falls inside the page window |

## Verification
The bench builds the block with its default parameters. These are a 16-bit logical space, a 4-bit page index, an 8-bit short operand, register addresses 0x15 and 0x11, and a reset page of 0x0E. With these values, every one of the sixteen page values can be stepped through the window. Both window edges (0x7FFF/0x8000 and 0xBFFF/0xC000) can be probed directly. A direct-page byte of 0x80 places short-form accesses inside the window, and one of 0x40 places them outside it. A mid-run reset shows that the write-once lock is released only by reset.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
  localparam int unsigned DEF_LOG_AW    = 16;
  localparam int unsigned DEF_PAGE_W    = 4;
  localparam int unsigned DEF_SHORT_W   = 8;
  localparam int unsigned DEF_RBUS_AW   = 8;
  localparam int unsigned DEF_RBUS_DW   = 8;
  localparam logic [7:0]  DEF_PAGE_REG  = 8'h15;
  localparam logic [7:0]  DEF_DPAGE_REG = 8'h11;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_PAGE  = 2'd1,
    SEL_DPAGE = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/pxl_regs.sv
module pxl_regs
  import pxl_pkg::*;
#(
  parameter int unsigned RBUS_AW   = DEF_RBUS_AW,
  parameter int unsigned RBUS_DW   = DEF_RBUS_DW,
  parameter int unsigned PAGE_W    = DEF_PAGE_W,
  parameter int unsigned DP_W      = 8,
  parameter logic [RBUS_AW-1:0] PAGE_REG  = DEF_PAGE_REG,
  parameter logic [RBUS_AW-1:0] DPAGE_REG = DEF_DPAGE_REG,
  parameter logic [PAGE_W-1:0]  PAGE_RST  = 4'hE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RBUS_AW-1:0] reg_addr,
  input  logic               reg_wr,
  input  logic [RBUS_DW-1:0] reg_wdata,
  output logic [RBUS_DW-1:0] reg_rdata,
  output logic [PAGE_W-1:0]  page_q,
  output logic [DP_W-1:0]    dp_q
);
  reg_sel_e sel;
  logic     dp_locked;
  logic     page_wr_ev;
  logic     dp_wr_ev;
  logic     dp_take_ev;

  function automatic reg_sel_e decode(input logic [RBUS_AW-1:0] a);
    if (a == PAGE_REG)  return SEL_PAGE;
    if (a == DPAGE_REG) return SEL_DPAGE;
    return SEL_NONE;
  endfunction

  always_comb sel = decode(reg_addr);

  assign page_wr_ev = reg_wr && (sel == SEL_PAGE);
  assign dp_wr_ev   = reg_wr && (sel == SEL_DPAGE);
  assign dp_take_ev = dp_wr_ev && !dp_locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= PAGE_RST;
    end else if (page_wr_ev) begin
      page_q <= reg_wdata[PAGE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_q      <= '0;
      dp_locked <= 1'b0;
    end else if (dp_take_ev) begin
      dp_q      <= reg_wdata[DP_W-1:0];
      dp_locked <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_PAGE:  reg_rdata[PAGE_W-1:0] = page_q;
      SEL_DPAGE: reg_rdata[DP_W-1:0]   = dp_q;
      default:   reg_rdata = '0;
    endcase
  end

  assert_page_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
    page_wr_ev |=> page_q == $past(reg_wdata[PAGE_W-1:0]));

  assert_dp_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dp_locked |=> $stable(dp_q));

  assert_dp_lock_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dp_wr_ev |=> dp_locked);

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != PAGE_REG && reg_addr != DPAGE_REG) |-> reg_rdata == '0);
endmodule

// File: rtl/pxl_xlat.sv
module pxl_xlat
  import pxl_pkg::*;
#(
  parameter int unsigned LOG_AW  = DEF_LOG_AW,
  parameter int unsigned PAGE_W  = DEF_PAGE_W,
  parameter int unsigned SHORT_W = DEF_SHORT_W,
  parameter logic [1:0]  WIN_TAG = 2'b10,
  localparam int unsigned DP_W    = LOG_AW - SHORT_W,
  localparam int unsigned OFF_W   = LOG_AW - 2,
  localparam int unsigned GLOB_AW = OFF_W + PAGE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LOG_AW-1:0]  cpu_addr,
  input  logic [SHORT_W-1:0] short_op,
  input  logic               direct_acc,
  input  logic [PAGE_W-1:0]  page_q,
  input  logic [DP_W-1:0]    dp_q,
  output logic [LOG_AW-1:0]  log_addr,
  output logic [GLOB_AW-1:0] glob_addr,
  output logic               win_hit
);
  function automatic logic [LOG_AW-1:0] form_logical(
    input logic dir, input logic [DP_W-1:0] dp,
    input logic [SHORT_W-1:0] s, input logic [LOG_AW-1:0] a);
    return dir ? {dp, s} : a;
  endfunction

  function automatic logic in_window(input logic [LOG_AW-1:0] a);
    return a[LOG_AW-1 -: 2] == WIN_TAG;
  endfunction

  function automatic logic [GLOB_AW-1:0] map_global(
    input logic [PAGE_W-1:0] pg, input logic [LOG_AW-1:0] a);
    if (in_window(a)) return {pg, a[OFF_W-1:0]};
    return {{(GLOB_AW-LOG_AW){1'b1}}, a};
  endfunction

  always_comb begin
    log_addr  = form_logical(direct_acc, dp_q, short_op, cpu_addr);
    win_hit   = in_window(log_addr);
    glob_addr = map_global(page_q, log_addr);
  end

  assert_window_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> glob_addr[GLOB_AW-1 -: PAGE_W] == page_q);

  assert_outside_prefix_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> (&glob_addr[GLOB_AW-1:LOG_AW]) && glob_addr[LOG_AW-1:0] == log_addr);

  assert_direct_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    direct_acc |-> log_addr[LOG_AW-1 -: DP_W] == dp_q);

  assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    glob_addr[OFF_W-1:0] == log_addr[OFF_W-1:0]);
endmodule

// File: rtl/paged_xlat.sv
module paged_xlat
  import pxl_pkg::*;
#(
  parameter int unsigned LOG_AW    = DEF_LOG_AW,
  parameter int unsigned PAGE_W    = DEF_PAGE_W,
  parameter int unsigned SHORT_W   = DEF_SHORT_W,
  parameter int unsigned RBUS_AW   = DEF_RBUS_AW,
  parameter int unsigned RBUS_DW   = DEF_RBUS_DW,
  parameter logic [RBUS_AW-1:0] PAGE_REG  = DEF_PAGE_REG,
  parameter logic [RBUS_AW-1:0] DPAGE_REG = DEF_DPAGE_REG,
  parameter logic [PAGE_W-1:0]  PAGE_RST  = 4'hE,
  localparam int unsigned DP_W    = LOG_AW - SHORT_W,
  localparam int unsigned GLOB_AW = LOG_AW - 2 + PAGE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LOG_AW-1:0]  cpu_addr,
  input  logic [SHORT_W-1:0] short_op,
  input  logic               direct_acc,
  input  logic [RBUS_AW-1:0] reg_addr,
  input  logic               reg_wr,
  input  logic [RBUS_DW-1:0] reg_wdata,
  output logic [RBUS_DW-1:0] reg_rdata,
  output logic [GLOB_AW-1:0] glob_addr,
  output logic               win_hit
);
  logic [PAGE_W-1:0] page_q;
  logic [DP_W-1:0]   dp_q;
  logic [LOG_AW-1:0] log_addr;

  pxl_regs #(
    .RBUS_AW(RBUS_AW), .RBUS_DW(RBUS_DW), .PAGE_W(PAGE_W), .DP_W(DP_W),
    .PAGE_REG(PAGE_REG), .DPAGE_REG(DPAGE_REG), .PAGE_RST(PAGE_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .page_q(page_q), .dp_q(dp_q)
  );

  pxl_xlat #(
    .LOG_AW(LOG_AW), .PAGE_W(PAGE_W), .SHORT_W(SHORT_W)
  ) u_xlat (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .short_op(short_op),
    .direct_acc(direct_acc), .page_q(page_q), .dp_q(dp_q),
    .log_addr(log_addr), .glob_addr(glob_addr), .win_hit(win_hit)
  );

  assert_rdata_hi_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[RBUS_DW-1:PAGE_W] == '0 || reg_addr == DPAGE_REG);
endmodule

// File: tb/paged_xlat_bench.sv
module paged_xlat_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  short_op = '0;
  logic        direct_acc = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [17:0] glob_addr;
  logic        win_hit;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_xlat u_paged_xlat (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .short_op(short_op),
    .direct_acc(direct_acc), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .glob_addr(glob_addr),
    .win_hit(win_hit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_glob(input int page, input int la);
    if (la >= 32'h8000 && la <= 32'hBFFF) return page * 32'h4000 + (la - 32'h8000);
    return 32'h30000 + la;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(req, {24'd0, reg_rdata}, {24'd0, exp});
  endtask

  task automatic probe(input string req, input int page, input logic [15:0] a);
    @(negedge clk);
    direct_acc = 1'b0; cpu_addr = a;
    #1;
    chk(req, {31'd0, win_hit}, {31'd0, (a >= 16'h8000 && a <= 16'hBFFF)});
    chk(req, {14'd0, glob_addr}, expect_glob(page, int'(a)));
  endtask

  task automatic probe_direct(input string req, input int page, input int dp, input logic [7:0] s);
    @(negedge clk);
    direct_acc = 1'b1; short_op = s; cpu_addr = 16'h1234;
    #1 chk(req, {14'd0, glob_addr}, expect_glob(page, dp * 256 + int'(s)));
    direct_acc = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    rd("R1 page reset", 8'h15, 8'h0E);
    rd("R1 dpage reset", 8'h11, 8'h00);
    probe("R1 reset page in window", 14, 16'h8001);
  endtask

  task automatic t_page();
    wr(8'h15, 8'hF7);
    rd("R2 upper bits zero", 8'h15, 8'h07);
    probe("R4 page 7", 7, 16'h8123);
    for (int p = 0; p < 16; p++) begin
      wr(8'h15, 8'(p));
      probe("R4 page sweep", p, 16'hA5A5);
    end
  endtask

  task automatic t_timing();
    wr(8'h15, 8'h0E);
    @(negedge clk);
    cpu_addr = 16'h8001; direct_acc = 1'b0;
    reg_addr = 8'h15; reg_wdata = 8'h03; reg_wr = 1'b1;
    #1 chk("R9 before edge", {14'd0, glob_addr}, expect_glob(14, 32'h8001));
    @(posedge clk);
    #1 chk("R9 after edge", {14'd0, glob_addr}, expect_glob(3, 32'h8001));
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic t_window();
    wr(8'h15, 8'h05);
    probe("R3 below window", 5, 16'h7FFF);
    probe("R3 window low edge", 5, 16'h8000);
    probe("R3 window high edge", 5, 16'hBFFF);
    probe("R5 above window", 5, 16'hC000);
    probe("R5 low map", 5, 16'h0042);
    probe("R5 top map", 5, 16'hFFFF);
  endtask

  task automatic t_direct();
    do_reset();
    wr(8'h15, 8'h09);
    probe_direct("R6 dp zero", 9, 0, 8'h77);
    wr(8'h11, 8'h80);
    rd("R7 first write", 8'h11, 8'h80);
    probe_direct("R6 dp in window", 9, 128, 8'h00);
    wr(8'h11, 8'h12);
    rd("R7 second write ignored", 8'h11, 8'h80);
    probe_direct("R7 mapping kept", 9, 128, 8'h34);
    do_reset();
    wr(8'h11, 8'h40);
    rd("R7 unlocked by reset", 8'h11, 8'h40);
    probe_direct("R6 dp outside window", 14, 64, 8'hCD);
    wr(8'h15, 8'h02);
    rd("R2 page writable after dp lock", 8'h15, 8'h02);
  endtask

  task automatic t_unmapped();
    wr(8'h16, 8'hFF);
    rd("R8 unmapped 0x16", 8'h16, 8'h00);
    rd("R8 unmapped 0x00", 8'h00, 8'h00);
    rd("R8 page untouched", 8'h15, 8'h02);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_page();
        t_timing();
        t_window();
        t_direct();
        t_unmapped();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule